// File: doc/BRIEF.md
# Multiplex-Aware Display RAM Writer

This block sits behind the serial command front end of a segment display driver. It takes display data bytes and stores them bit by bit in a display RAM of 60 addresses by 4 rows. Each row of an address belongs to one backplane. The number of rows filled at each address follows the current multiplex mode: one row in static drive, and two, three or four rows in the multiplexed modes. After each group of rows is filled, the write address moves on by one.

The front end reports four kinds of events: a data byte, a new pointer value, a device-select subaddress, and a mode update that carries both the multiplex mode and the output bank. Several devices can share one bus. Each of them keeps the data bytes only while the last device-select subaddress matched its own 3-bit hardware subaddress. The full RAM image is brought out for the waveform logic. In static drive, a bank selector also brings out one chosen row of every address as the segment pattern.

A small state machine unpacks each accepted byte. It waits in `ST_IDLE`. The transition *accept* (a data byte arrives while the device is selected) moves it to `ST_PACK`. In `ST_PACK` it writes one bit per cycle, MSB first. The transition *last bit* (the eighth bit has been written) returns it to `ST_IDLE`. The front end delivers bytes at least nine cycles apart and issues commands only while no byte is being unpacked.

Top module: `disp_ram_writer`

## Requirements
- R1: After reset the RAM is all zero, the pointer and row phase are 0, the mode is static (mode code 0), the bank is 0 and the device is deselected, so a data byte arriving before any device select changes no RAM bit.
- R2: A device select whose subaddress equals `hw_subaddr` selects the device, and any other value deselects it. A data byte that arrives while the device is deselected changes no RAM bit and does not move the pointer.
- R3: A pointer load sets the write address to `ptr_value` and the row phase to 0. A value of 60 or more loads address 0.
- R4: An accepted byte is written MSB first, one bit per cycle. Bit 7 is written at the second rising edge after the byte is sampled, and each following bit one edge later. Within an address, successive bits fill row 0, then row 1, and so on, and only one RAM bit can change per cycle.
- R5: Mode code m (0 static, 1 two rows, 2 three rows, 3 four rows) writes m+1 consecutive bits to rows 0..m of an address and then moves the pointer to the next address.
- R6: In the three-row mode the bits left over at the end of a byte stay at the current address. The next selected byte completes that group, starting at the pending row.
- R7: The pointer wraps from address 59 to address 0, including when the wrap falls inside a byte or completes a group carried over from the previous byte.
- R8: Rows of an address that the current mode does not write keep their previous contents.
- R9: In static mode `bank_bits[a]` equals row `bank` of address a. In every other mode it equals row 0, whatever the bank value.
- R10: A mode update resets the row phase to 0 and leaves the pointer unchanged.
- R11: `ram_q[a*4 + r]` holds row r of address a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_subaddr | input | 3 | This device's hardware subaddress |
| sel_valid | input | 1 | Device-select event strobe |
| sel_addr | input | 3 | Subaddress carried by the device select |
| ptr_valid | input | 1 | Pointer-load event strobe |
| ptr_value | input | 6 | New RAM address |
| mode_valid | input | 1 | Mode-update event strobe |
| mode_value | input | 2 | Multiplex mode code (rows minus one) |
| bank_value | input | 2 | Output bank (row) for static drive |
| data_valid | input | 1 | Display data byte strobe |
| data_byte | input | 8 | Display data byte |
| ram_q | output | 240 | Full RAM image, address-major |
| bank_bits | output | 60 | Bank-selected row per address |

## Verification
The hardest coincidence is a pointer wrap and a three-row group that carries over a byte boundary landing on the same write. To provoke it, the pointer is loaded to 57 in the three-row mode: the first byte leaves address 59 with only two rows filled, and the first bit of the next byte must complete row 2 of address 59 in the same step that moves the pointer to 0. A bit-accurate model in the bench applies one bit per cycle, and the full RAM image is compared after every edge of every byte. A group split at the wrong moment, or a wrap taken from the wrong row, therefore appears as a mismatch at the exact cycle it happens.

// File: rtl/dwr_pkg.sv
package dwr_pkg;

    // Unpacker states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PACK = 1'b1
    } wr_state_e;

    // Mode code for static drive: a single row per address
    localparam logic [1:0] MODE_STATIC = 2'd0;

endpackage

// File: rtl/dwr_ctrl.sv
module dwr_ctrl #(
    parameter int ROWS  = 4,
    parameter int SUB_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SUB_W-1:0]         hw_subaddr,
    input  logic                     sel_valid,
    input  logic [SUB_W-1:0]         sel_addr,
    input  logic                     mode_valid,
    input  logic [$clog2(ROWS)-1:0]  mode_value,
    input  logic [$clog2(ROWS)-1:0]  bank_value,
    output logic [$clog2(ROWS)-1:0]  mode_q,
    output logic [$clog2(ROWS)-1:0]  bank_q,
    output logic                     sel_q
);
    localparam int ROW_W = $clog2(ROWS);

    // Configuration registers written by a mode update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            bank_q <= '0;
        end else if (mode_valid) begin
            mode_q <= mode_value;
            bank_q <= bank_value;
        end
    end

    // Subaddress gate: every select event either matches or clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (sel_valid) begin
            sel_q <= (sel_addr == hw_subaddr);
        end
    end

    logic [ROW_W-1:0] unused_w;
    assign unused_w = '0;

endmodule

// File: rtl/dwr_ptr.sv
module dwr_ptr #(
    parameter int ADDRS = 60,
    parameter int ROWS  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [$clog2(ADDRS)-1:0]  load_val,
    input  logic                      rephase,
    input  logic                      step,
    input  logic [$clog2(ROWS)-1:0]   rows_m1,
    output logic [$clog2(ADDRS)-1:0]  ptr_q,
    output logic [$clog2(ROWS)-1:0]   row_q
);
    localparam int ADDR_W = $clog2(ADDRS);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(ADDRS - 1);

    logic group_done;
    logic at_last;
    logic load_ok;

    assign group_done = (row_q == rows_m1);
    assign at_last    = (ptr_q == LAST_ADDR);
    assign load_ok    = (load_val <= LAST_ADDR);

    // Pointer load beats a mode-driven rephase, which beats a bit step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            row_q <= '0;
        end else if (load) begin
            ptr_q <= load_ok ? load_val : '0;
            row_q <= '0;
        end else if (rephase) begin
            row_q <= '0;
        end else if (step) begin
            if (group_done) begin
                row_q <= '0;
                ptr_q <= at_last ? '0 : ptr_q + 1'b1;
            end else begin
                row_q <= row_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dwr_store.sv
module dwr_store #(
    parameter int ADDRS = 60,
    parameter int ROWS  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [$clog2(ADDRS)-1:0]  waddr,
    input  logic [$clog2(ROWS)-1:0]   wrow,
    input  logic                      wbit,
    input  logic                      static_mode,
    input  logic [$clog2(ROWS)-1:0]   bank,
    output logic [ADDRS*ROWS-1:0]     ram_q,
    output logic [ADDRS-1:0]          bank_bits
);
    logic [ROWS-1:0] mem [ADDRS];

    // Single-bit write port; all other cells hold their value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < ADDRS; a++) begin
                mem[a] <= '0;
            end
        end else if (we) begin
            mem[waddr][wrow] <= wbit;
        end
    end

    // Flatten the array and apply the static-drive bank selector per address
    for (genvar a = 0; a < ADDRS; a++) begin : g_addr
        assign ram_q[a*ROWS +: ROWS] = mem[a];
        assign bank_bits[a] = static_mode ? mem[a][bank] : mem[a][0];
    end

endmodule

// File: rtl/disp_ram_writer.sv
module disp_ram_writer #(
    parameter int ADDRS  = 60,
    parameter int ROWS   = 4,
    parameter int BYTE_W = 8,
    parameter int SUB_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SUB_W-1:0]            hw_subaddr,
    input  logic                        sel_valid,
    input  logic [SUB_W-1:0]            sel_addr,
    input  logic                        ptr_valid,
    input  logic [$clog2(ADDRS)-1:0]    ptr_value,
    input  logic                        mode_valid,
    input  logic [$clog2(ROWS)-1:0]     mode_value,
    input  logic [$clog2(ROWS)-1:0]     bank_value,
    input  logic                        data_valid,
    input  logic [BYTE_W-1:0]           data_byte,
    output logic [ADDRS*ROWS-1:0]       ram_q,
    output logic [ADDRS-1:0]            bank_bits
);
    import dwr_pkg::*;

    localparam int ADDR_W = $clog2(ADDRS);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int CNT_W  = $clog2(BYTE_W);

    wr_state_e          state_q, state_d;
    logic [BYTE_W-1:0]  shreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               accept;
    logic               step;
    logic               packing;

    logic [ROW_W-1:0]   mode_q;
    logic [ROW_W-1:0]   bank_q;
    logic               sel_q;
    logic [ADDR_W-1:0]  ptr_q;
    logic [ROW_W-1:0]   row_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (data_valid && sel_q) state_d = ST_PACK;
            ST_PACK: if (cnt_q == '0)         state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        accept = 1'b0;
        step   = 1'b0;
        unique case (state_q)
            ST_IDLE: accept = data_valid && sel_q;
            ST_PACK: step   = 1'b1;
        endcase
    end

    assign packing = (state_q == ST_PACK);

    // Byte shifter and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (accept) begin
            shreg_q <= data_byte;
            cnt_q   <= CNT_W'(BYTE_W - 1);
        end else if (step) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    dwr_ctrl #(
        .ROWS  (ROWS),
        .SUB_W (SUB_W)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_subaddr (hw_subaddr),
        .sel_valid  (sel_valid),
        .sel_addr   (sel_addr),
        .mode_valid (mode_valid),
        .mode_value (mode_value),
        .bank_value (bank_value),
        .mode_q     (mode_q),
        .bank_q     (bank_q),
        .sel_q      (sel_q)
    );

    dwr_ptr #(
        .ADDRS (ADDRS),
        .ROWS  (ROWS)
    ) i_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_valid),
        .load_val (ptr_value),
        .rephase  (mode_valid),
        .step     (step),
        .rows_m1  (mode_q),
        .ptr_q    (ptr_q),
        .row_q    (row_q)
    );

    dwr_store #(
        .ADDRS (ADDRS),
        .ROWS  (ROWS)
    ) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (step),
        .waddr       (ptr_q),
        .wrow        (row_q),
        .wbit        (shreg_q[BYTE_W-1]),
        .static_mode (mode_q == ROW_W'(MODE_STATIC)),
        .bank        (bank_q),
        .ram_q       (ram_q),
        .bank_bits   (bank_bits)
    );

endmodule

// File: rtl/dwr_checker.sv
module dwr_checker #(
    parameter int ADDRS = 60,
    parameter int ROWS  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      packing,
    input logic                      selected,
    input logic [$clog2(ADDRS)-1:0]  ptr,
    input logic [$clog2(ROWS)-1:0]   row,
    input logic [$clog2(ROWS)-1:0]   mode,
    input logic                      ptr_valid,
    input logic [$clog2(ADDRS)-1:0]  ptr_value,
    input logic                      mode_valid,
    input logic [ADDRS*ROWS-1:0]     ram_q
);
    localparam int ADDR_W = $clog2(ADDRS);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(ADDRS - 1);

    a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST_ADDR);

    a_r3_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_valid && ptr_value <= LAST_ADDR) |=> (ptr == $past(ptr_value) && row == '0));

    a_r5_row_within_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_valid |-> row <= mode);

    a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (packing && !ptr_valid && !mode_valid && ptr == LAST_ADDR && row == mode) |=> ptr == '0);

    a_r4_one_bit_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        packing |=> $countones(ram_q ^ $past(ram_q)) <= 1);

    a_r2_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !packing |=> $stable(ram_q));

    a_r2_deselected_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!selected && !packing) |=> !packing);

    a_r10_mode_rephase: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid && !ptr_valid) |=> (row == '0 && $stable(ptr)));

endmodule

bind disp_ram_writer dwr_checker #(
    .ADDRS (ADDRS),
    .ROWS  (ROWS)
) i_dwr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .packing    (packing),
    .selected   (sel_q),
    .ptr        (ptr_q),
    .row        (row_q),
    .mode       (mode_q),
    .ptr_valid  (ptr_valid),
    .ptr_value  (ptr_value),
    .mode_valid (mode_valid),
    .ram_q      (ram_q)
);

// File: tb/test_disp_ram_writer.sv
module test_disp_ram_writer;
    localparam int CLK_PERIOD = 10;
    localparam int ADDRS  = 60;
    localparam int ROWS   = 4;
    localparam int BYTE_W = 8;
    localparam int SUB_W  = 3;
    localparam int ADDR_W = 6;
    localparam logic [SUB_W-1:0] HW_SUB = 3'd5;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [SUB_W-1:0]       sel_addr = '0;
    logic                   sel_valid = 1'b0;
    logic                   ptr_valid = 1'b0;
    logic [ADDR_W-1:0]      ptr_value = '0;
    logic                   mode_valid = 1'b0;
    logic [1:0]             mode_value = '0;
    logic [1:0]             bank_value = '0;
    logic                   data_valid = 1'b0;
    logic [BYTE_W-1:0]      data_byte = '0;
    logic [ADDRS*ROWS-1:0]  ram_q;
    logic [ADDRS-1:0]       bank_bits;

    logic [ADDRS*ROWS-1:0]  exp_ram = '0;
    int  m_ptr = 0, m_row = 0, m_mode = 0, m_bank = 0;
    bit  m_sel = 1'b0;
    int  checks = 0, fails = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_ram_writer #(
        .ADDRS (ADDRS), .ROWS (ROWS), .BYTE_W (BYTE_W), .SUB_W (SUB_W)
    ) i_disp_ram_writer (
        .clk (clk), .rst_n (rst_n), .hw_subaddr (HW_SUB),
        .sel_valid (sel_valid), .sel_addr (sel_addr),
        .ptr_valid (ptr_valid), .ptr_value (ptr_value),
        .mode_valid (mode_valid), .mode_value (mode_value), .bank_value (bank_value),
        .data_valid (data_valid), .data_byte (data_byte),
        .ram_q (ram_q), .bank_bits (bank_bits)
    );

    task automatic check_ram(input string req);
        checks++;
        if (ram_q !== exp_ram) begin
            fails++;
            $display("FAIL %s ram_q actual %h expected %h", req, ram_q, exp_ram);
        end
    endtask

    task automatic check_bank(input string req);
        logic [ADDRS-1:0] e;
        for (int a = 0; a < ADDRS; a++)
            e[a] = (m_mode == 0) ? exp_ram[a*ROWS + m_bank] : exp_ram[a*ROWS];
        checks++;
        if (bank_bits !== e) begin
            fails++;
            $display("FAIL %s bank_bits actual %h expected %h", req, bank_bits, e);
        end
    endtask

    // Model of one written bit: row r of address a sits at a*ROWS + r (R11)
    task automatic model_bit(input logic b);
        exp_ram[m_ptr*ROWS + m_row] = b;
        if (m_row == m_mode) begin
            m_row = 0;
            m_ptr = (m_ptr == ADDRS-1) ? 0 : m_ptr + 1;
        end else begin
            m_row++;
        end
    endtask

    task automatic send_byte(input logic [BYTE_W-1:0] v, input string req);
        @(negedge clk);
        data_valid = 1'b1;
        data_byte  = v;
        @(negedge clk);
        data_valid = 1'b0;
        check_ram(req);
        for (int k = 0; k < BYTE_W; k++) begin
            @(negedge clk);
            if (m_sel) model_bit(v[BYTE_W-1-k]);
            check_ram(req);
        end
    endtask

    task automatic send_sel(input logic [SUB_W-1:0] a);
        @(negedge clk);
        sel_valid = 1'b1;
        sel_addr  = a;
        @(negedge clk);
        sel_valid = 1'b0;
        m_sel = (a == HW_SUB);
    endtask

    task automatic send_ptr(input int v);
        @(negedge clk);
        ptr_valid = 1'b1;
        ptr_value = ADDR_W'(v);
        @(negedge clk);
        ptr_valid = 1'b0;
        m_ptr = (v < ADDRS) ? v : 0;
        m_row = 0;
    endtask

    task automatic send_mode(input int m, input int b);
        @(negedge clk);
        mode_valid = 1'b1;
        mode_value = 2'(m);
        bank_value = 2'(b);
        @(negedge clk);
        mode_valid = 1'b0;
        m_mode = m;
        m_bank = b;
        m_row  = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual 200000 cycles, expected fewer");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_ram("R1");
        check_bank("R1");
        send_byte(8'hFF, "R1");

        // R2: mismatched select ignores data, then a match enables it
        send_sel(HW_SUB ^ 3'b001);
        send_byte(8'hA5, "R2");
        send_sel(HW_SUB);
        send_byte(8'hC3, "R2");

        // Sweeps over every mode, four rows first so lower modes overwrite part of it
        for (int m = 3; m >= 0; m--) begin
            int nb;
            send_mode(m, 0);
            send_ptr(0);
            nb = (ADDRS*(m+1) + BYTE_W - 1) / BYTE_W + 2;
            for (int i = 0; i < nb; i++) begin
                logic [BYTE_W-1:0] v;
                v = BYTE_W'(i*37 + m*11 + 8'h5A);
                if (m == 3)      send_byte(v, "R4");
                else if (m == 2) send_byte(v, "R6");
                else             send_byte(v, "R5");
            end
            check_ram("R8");
            check_bank("R9");
        end

        // R7: three-row group left at address 59 completes as the pointer wraps
        send_mode(2, 0);
        send_ptr(57);
        send_byte(8'h96, "R7");
        send_byte(8'h3C, "R7");
        send_ptr(59);
        send_byte(8'hE1, "R7");

        // R3: out-of-range load goes to 0; mid-range load in two-row mode
        send_mode(3, 0);
        send_ptr(63);
        send_byte(8'h5B, "R3");
        send_mode(1, 0);
        send_ptr(30);
        send_byte(8'hD2, "R3");

        // R10: a mode update in the middle of a group restarts the row phase
        send_mode(2, 0);
        send_ptr(10);
        send_byte(8'h71, "R10");
        send_mode(2, 0);
        send_byte(8'h8E, "R10");

        // R9: bank selector in static drive and ignored otherwise
        for (int b = 0; b < ROWS; b++) begin
            send_mode(0, b);
            check_bank("R9");
        end
        send_mode(1, 3);
        check_bank("R9");
        send_mode(3, 2);
        check_bank("R9");

        // R11: address-major layout of the full image
        check_ram("R11");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule